// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

This block is a watchdog timer on a small memory-mapped register bus. Software programs a timeout, sets the enable bit, and must then refresh the watchdog on time by writing two fixed key words, in order, to the service register. If it does not, the down-counter reaches zero and a sticky expiry output asserts. The expiry output stays high until the block is reset, and it is normally wired to a system reset controller.

The counter runs on the bus clock. It takes a new value from the timeout register only when a complete key pair arrives or when the enable bit goes from 0 to 1. Any programmed timeout below 256 is raised to 256 when it is loaded. Counting can be suspended while a debug-halt input or a low-power input is high, but only if the matching freeze bit is set in the control register. Software can read the live count only while the watchdog is disabled. While it is enabled, reads of the count return zero.

The register offsets are: control 0x00, timeout 0x08, service 0x10 and count 0x14. Reads are combinational, and read data is zero when the read strobe is low.

Top module: `keyed_wdt`

## Requirements
- R1: After reset, the control register reads 0, the timeout register reads 0x800, the count reads 0 and the expiry output is low.
- R2: A write to control with bit 0 set, when bit 0 was clear, loads the counter from the timeout at that clock edge. On every later edge where the counter is enabled and not frozen, it decreases by exactly one.
- R3: A timeout value below 0x100 is loaded into the counter as 0x100. The timeout register itself reads back the value that was written.
- R4: The counter reloads when 0x0000A602 is written to offset 0x10 and 0x0000B480 is written there as the next service write. The reload happens on the edge of the second write.
- R5: A service write that is not the expected next key returns the sequence to expecting 0x0000A602. A wrong word after 0x0000A602 therefore causes no reload, and neither does a following 0x0000B480.
- R6: Writing the timeout register while the counter runs does not change the running count.
- R7: A read of offset 0x14 returns the count while control bit 0 is clear, and returns 0 while it is set.
- R8: Clearing control bit 0 stops the count. Setting the bit again restarts the count from the timeout value.
- R9: When the enabled count is at zero, the expiry output rises on the next edge and stays high until reset, including after the watchdog is disabled.
- R10: Control bit 1 set together with the debug-halt input high holds the count. With bit 1 clear, the debug-halt input has no effect.
- R11: Control bit 2 set together with the low-power input high holds the count. With bit 2 clear, the low-power input has no effect.
- R12: Control bits 10:9 (service-mode select, 00 = fixed key pair) and bits 2:0 read back as written. The other control bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and counter clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Combinational read data, zero when bus_re is low |
| dbg_halt_i | input | 1 | Debug-halt state of the system |
| lowpwr_i | input | 1 | Low-power state of the system |
| wdt_expired_o | output | 1 | Sticky expiry indication |

## Verification
The assertions assume that each write strobe lasts exactly one clock cycle, and that the halt and low-power inputs change only between clock edges. The bench drives every input on the falling edge and holds each write strobe for a single cycle, so the stimulus never breaks these assumptions. The assertions also assume that reset is held high from time zero until the first edges, so that no `$past` value is read before reset. The bench holds reset for several cycles to meet this.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int TMO_W  = 32;
    localparam int DATA_W = 32;

    localparam logic [7:0] OFS_CTRL = 8'h00;
    localparam logic [7:0] OFS_TMO  = 8'h08;
    localparam logic [7:0] OFS_SVC  = 8'h10;
    localparam logic [7:0] OFS_CNT  = 8'h14;

    localparam logic [DATA_W-1:0] KEY_FIRST  = 32'h0000_A602;
    localparam logic [DATA_W-1:0] KEY_SECOND = 32'h0000_B480;

    typedef struct packed {
        logic [1:0] svc_mode;
        logic       stop_frz;
        logic       dbg_frz;
        logic       en;
    } ctrl_t;

    typedef enum logic {
        KEY_WAIT_FIRST  = 1'b0,
        KEY_WAIT_SECOND = 1'b1
    } key_state_e;

    function automatic logic [TMO_W-1:0] clamp_tmo(input logic [TMO_W-1:0] raw,
                                                   input logic [TMO_W-1:0] floor_v);
        return (raw < floor_v) ? floor_v : raw;
    endfunction

    function automatic logic [DATA_W-1:0] pack_ctrl(input ctrl_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[0]    = c.en;
        w[1]    = c.dbg_frz;
        w[2]    = c.stop_frz;
        w[10:9] = c.svc_mode;
        return w;
    endfunction

endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter logic [TMO_W-1:0] TMO_RESET = 32'h0000_0800
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              we,
    input  logic              re,
    input  logic [TMO_W-1:0]  cnt,
    output logic [DATA_W-1:0] rdata,
    output ctrl_t             ctrl,
    output logic [TMO_W-1:0]  tmo,
    output logic              start_pulse,
    output logic              svc_wr,
    output logic [DATA_W-1:0] svc_data
);

    logic ctrl_wr;
    logic tmo_wr;

    assign ctrl_wr  = we && (addr == OFS_CTRL);
    assign tmo_wr   = we && (addr == OFS_TMO);
    assign svc_wr   = we && (addr == OFS_SVC);
    assign svc_data = wdata;

    assign start_pulse = ctrl_wr && wdata[0] && !ctrl.en;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
            tmo  <= TMO_RESET;
        end else begin
            if (ctrl_wr) begin
                ctrl.en       <= wdata[0];
                ctrl.dbg_frz  <= wdata[1];
                ctrl.stop_frz <= wdata[2];
                ctrl.svc_mode <= wdata[10:9];
            end
            if (tmo_wr) begin
                tmo <= wdata;
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (re) begin
            unique case (addr)
                OFS_CTRL: rdata = pack_ctrl(ctrl);
                OFS_TMO:  rdata = tmo;
                OFS_CNT:  rdata = ctrl.en ? '0 : cnt;
                default:  rdata = '0;
            endcase
        end
    end

    AST_CNT_HIDDEN: assert property (@(posedge clk) disable iff (rst)
        (re && addr == OFS_CNT && ctrl.en) |-> (rdata == '0)); // R7

    AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr |=> (pack_ctrl(ctrl) == ($past(wdata) & 32'h0000_0607))); // R12

endmodule

// File: rtl/wdt_key_seq.sv
module wdt_key_seq
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              svc_wr,
    input  logic [DATA_W-1:0] svc_data,
    output logic              svc_ok
);

    key_state_e state_q;
    key_state_e state_d;

    always_comb begin
        state_d = state_q;
        svc_ok  = 1'b0;
        if (svc_wr) begin
            if (state_q == KEY_WAIT_FIRST && svc_data == KEY_FIRST) begin
                state_d = KEY_WAIT_SECOND;
            end else if (state_q == KEY_WAIT_SECOND && svc_data == KEY_SECOND) begin
                state_d = KEY_WAIT_FIRST;
                svc_ok  = 1'b1;
            end else begin
                state_d = KEY_WAIT_FIRST;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= KEY_WAIT_FIRST;
        else     state_q <= state_d;
    end

    AST_KEY_SECOND_ONLY: assert property (@(posedge clk) disable iff (rst)
        svc_ok |-> (svc_wr && svc_data == KEY_SECOND)); // R4

    AST_KEY_FIRST_SEEN: assert property (@(posedge clk) disable iff (rst)
        svc_ok |-> $past(svc_wr && svc_data == KEY_FIRST) || !$past(svc_wr)); // R5

    AST_KEY_WRONG_RESETS: assert property (@(posedge clk) disable iff (rst)
        (svc_wr && svc_data != KEY_FIRST && svc_data != KEY_SECOND)
            |=> (state_q == KEY_WAIT_FIRST)); // R5

endmodule

// File: rtl/wdt_count.sv
module wdt_count
    import wdt_pkg::*;
#(
    parameter logic [TMO_W-1:0] TMO_MIN = 32'h0000_0100
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             frozen,
    input  logic             load,
    input  logic [TMO_W-1:0] tmo,
    output logic [TMO_W-1:0] cnt_q,
    output logic             expired_q
);

    logic at_zero;

    assign at_zero = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= '0;
            expired_q <= 1'b0;
        end else begin
            if (load) begin
                cnt_q <= clamp_tmo(tmo, TMO_MIN);
            end else if (en && !frozen && !at_zero) begin
                cnt_q <= cnt_q - 1'b1;
            end
            if (en && at_zero && !load) begin
                expired_q <= 1'b1;
            end
        end
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (en && !frozen && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R2

    AST_LOAD_FLOOR: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt_q >= TMO_MIN)); // R3

    AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (frozen && !load) |=> $stable(cnt_q)); // R10

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!en && !load) |=> $stable(cnt_q)); // R8

    AST_EXPIRED_STICKY: assert property (@(posedge clk) disable iff (rst)
        expired_q |=> expired_q); // R9

endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
    import wdt_pkg::*;
#(
    parameter logic [TMO_W-1:0] TMO_RESET = 32'h0000_0800,
    parameter logic [TMO_W-1:0] TMO_MIN   = 32'h0000_0100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              dbg_halt_i,
    input  logic              lowpwr_i,
    output logic              wdt_expired_o
);

    ctrl_t             ctrl;
    logic [TMO_W-1:0]  tmo;
    logic [TMO_W-1:0]  cnt;
    logic              start_pulse;
    logic              svc_wr;
    logic [DATA_W-1:0] svc_data;
    logic              svc_ok;
    logic              frozen;
    logic              load;

    assign frozen = (ctrl.dbg_frz && dbg_halt_i) || (ctrl.stop_frz && lowpwr_i);
    assign load   = start_pulse || svc_ok;

    wdt_regs #(.TMO_RESET(TMO_RESET)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .addr        (bus_addr),
        .wdata       (bus_wdata),
        .we          (bus_we),
        .re          (bus_re),
        .cnt         (cnt),
        .rdata       (bus_rdata),
        .ctrl        (ctrl),
        .tmo         (tmo),
        .start_pulse (start_pulse),
        .svc_wr      (svc_wr),
        .svc_data    (svc_data)
    );

    wdt_key_seq u_keys (
        .clk      (clk),
        .rst      (rst),
        .svc_wr   (svc_wr),
        .svc_data (svc_data),
        .svc_ok   (svc_ok)
    );

    wdt_count #(.TMO_MIN(TMO_MIN)) u_count (
        .clk       (clk),
        .rst       (rst),
        .en        (ctrl.en),
        .frozen    (frozen),
        .load      (load),
        .tmo       (tmo),
        .cnt_q     (cnt),
        .expired_q (wdt_expired_o)
    );

    AST_OPT_OUT_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (ctrl.en && !ctrl.dbg_frz && !ctrl.stop_frz && !load && cnt != '0)
            |=> (cnt != $past(cnt))); // R11

endmodule

// File: tb/sim_keyed_wdt.sv
module sim_keyed_wdt;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_rdata;
    logic        dbg_halt_i = 1'b0;
    logic        lowpwr_i = 1'b0;
    logic        wdt_expired_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    keyed_wdt u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .dbg_halt_i(dbg_halt_i), .lowpwr_i(lowpwr_i), .wdt_expired_o(wdt_expired_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // all tasks are entered at a falling edge (or just after one)
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a; bus_re = 1'b1;
        #1 d = bus_rdata;
        bus_re = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        idle(3);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        do_reset();
        rd(8'h00, v); check("R1 ctrl", v, 32'h0);
        rd(8'h08, v); check("R1 tmo", v, 32'h800);
        rd(8'h14, v); check("R1 cnt", v, 32'h0);
        check("R1 expired", {31'b0, wdt_expired_o}, 32'h0);
    endtask

    task automatic t_count_and_restart();
        logic [31:0] v;
        do_reset();
        wr(8'h08, 32'd1000);
        wr(8'h00, 32'h1);          // load 1000
        idle(20);
        rd(8'h14, v); check("R7 hidden while enabled", v, 32'h0);
        wr(8'h08, 32'd5000);       // R6: running count untouched
        wr(8'h00, 32'h0);
        rd(8'h14, v); check("R2 R6 countdown", v, 32'd1000 - 32'd22);
        idle(30);
        rd(8'h14, v); check("R8 stopped", v, 32'd978);
        wr(8'h00, 32'h1);          // reload 5000
        wr(8'h00, 32'h0);
        rd(8'h14, v); check("R8 restart from timeout", v, 32'd4999);
    endtask

    task automatic t_service();
        logic [31:0] v;
        do_reset();
        wr(8'h08, 32'd1000);
        wr(8'h00, 32'h1);
        idle(100);
        wr(8'h10, 32'h0000_A602);
        wr(8'h10, 32'h0000_B480);  // reload 1000
        wr(8'h00, 32'h0);
        rd(8'h14, v); check("R4 service reload", v, 32'd999);
        wr(8'h00, 32'h1);          // E0: load 1000
        idle(100);                 // E1..E100
        wr(8'h10, 32'h0000_A602);  // E101
        wr(8'h10, 32'h0000_1234);  // E102 wrong
        wr(8'h10, 32'h0000_B480);  // E103 no reload
        wr(8'h00, 32'h0);          // E104
        rd(8'h14, v); check("R5 wrong key no reload", v, 32'd1000 - 32'd104);
        wr(8'h00, 32'h1);
        wr(8'h10, 32'h0000_A602);
        wr(8'h10, 32'h0000_A602);  // resets sequence
        wr(8'h10, 32'h0000_B480);  // not a pair completion
        wr(8'h00, 32'h0);
        rd(8'h14, v); check("R5 repeated first key", v, 32'd996);
    endtask

    task automatic t_expire();
        logic [31:0] v;
        do_reset();
        wr(8'h08, 32'h10);
        rd(8'h08, v); check("R3 raw readback", v, 32'h10);
        wr(8'h00, 32'h1);          // E0: load clamped 256
        idle(256);                 // through E256, count at zero
        check("R3 R9 not yet expired", {31'b0, wdt_expired_o}, 32'h0);
        idle(1);
        check("R3 R9 expired", {31'b0, wdt_expired_o}, 32'h1);
        wr(8'h00, 32'h0);
        idle(10);
        check("R9 sticky", {31'b0, wdt_expired_o}, 32'h1);
        do_reset();
        check("R9 cleared by reset", {31'b0, wdt_expired_o}, 32'h0);
    endtask

    task automatic t_freeze();
        logic [31:0] v;
        do_reset();
        wr(8'h08, 32'd1000);
        dbg_halt_i = 1'b1;
        wr(8'h00, 32'h3);
        idle(50);
        wr(8'h00, 32'h0);
        rd(8'h14, v); check("R10 debug freeze", v, 32'd1000);
        wr(8'h00, 32'h1);
        idle(50);
        wr(8'h00, 32'h0);
        rd(8'h14, v); check("R10 debug ignored", v, 32'd949);
        dbg_halt_i = 1'b0;
        lowpwr_i = 1'b1;
        wr(8'h00, 32'h5);
        idle(50);
        wr(8'h00, 32'h0);
        rd(8'h14, v); check("R11 stop freeze", v, 32'd1000);
        wr(8'h00, 32'h1);
        idle(50);
        wr(8'h00, 32'h0);
        rd(8'h14, v); check("R11 stop ignored", v, 32'd949);
        lowpwr_i = 1'b0;
    endtask

    task automatic t_ctrl_fields();
        logic [31:0] v;
        do_reset();
        wr(8'h00, 32'hFFFF_F9FE);
        rd(8'h00, v); check("R12 reserved bits", v, 32'h0000_0006);
        wr(8'h00, 32'h0000_0606);
        rd(8'h00, v); check("R12 mode readback", v, 32'h0000_0606);
    endtask

    initial begin
        fork
            begin
                @(negedge clk);
                t_reset();
                t_count_and_restart();
                t_service();
                t_expire();
                t_freeze();
                t_ctrl_fields();
            end
            begin
                repeat (100000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog timeout actual=hung expected=done");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule